// File: doc/BRIEF.md
# Dual-Rate Codec Sample Scheduler

This block paces two sample streams from one master clock: an audio stream and a telecom stream. Each stream has its own programmable slot period and its own pair of FIFOs, one for transmit and one for receive. At every slot the block sends the oldest queued transmit sample to the codec side and takes one receive sample back. Status flags report FIFO fill levels, under-runs and over-runs, and a single interrupt line combines the four maskable FIFO service requests.

A third channel queues codec register commands, each carrying an address, a direction and a data word. The block issues them one at a time on a request/acknowledge handshake and raises a completion flag for writes and another for reads. The read data is kept for the host. The host uses a plain register port: writes take effect on the clock edge, and reads are combinational from the address. A read of a data register removes the head of the receive FIFO on that edge. A loopback switch feeds each stream's transmitted sample into its own receive FIFO.

Top module: `codec_slot_sched`

## Requirements
- R1: After reset no slot strobe, command request or interrupt is active, all FIFOs are empty, and the status register (address 4) reads 0x0505.
- R2: While the enable bit (CTRL bit 16) is set, `aud_strobe` pulses for one cycle every 32*max(A,6) master cycles, where A is CTRL bits 6:0. While the enable bit is clear there are no audio strobes.
- R3: While enabled, `tel_strobe` pulses every 32*max(T,16) master cycles, where T is CTRL bits 14:8.
- R4: Audio samples are 12 bits, written and read at bits 15:4 of address 1. Telecom samples are 14 bits at bits 15:2 of address 2. Each slot presents the transmit FIFO head, in write order, on the stream's sample output while its strobe is high.
- R5: A slot that finds the transmit FIFO empty repeats the previous sample and sets the under-run flag (status bit 4 audio, bit 12 telecom). Writing 1 to that bit clears it.
- R6: In the strobe cycle the receive sample input is stored in the 8-deep receive FIFO. If that FIFO is full, the sample is dropped and the over-run flag is set (status bit 5 audio, bit 13 telecom, cleared by writing 1). Reading an empty receive FIFO returns 0.
- R7: With loopback (CTRL bit 17) set, the receive FIFO stores the sample being transmitted instead of the external input.
- R8: Per stream (audio bits 3:0, telecom bits 11:8), the status holds: the transmit request (transmit count at most 4), the receive request (receive count at least 4), transmit not-full, and receive not-empty, in that bit order.
- R9: `irq` is high exactly when the block is enabled and one of the four requests {telecom rx, telecom tx, audio rx, audio tx} is set together with its enable bit in CTRL bits 21:18 (bit 18 audio tx up to bit 21 telecom rx).
- R10: A write to address 3 queues a command: bits 15:0 data, bit 16 set for write, bits 20:17 register address. Commands go out in order on `cmd_word` while enabled, and `cmd_req` and `cmd_word` are held until `cmd_ack`.
- R11: An acknowledged write command sets status bit 16. An acknowledged read command sets status bit 17 and stores `cmd_rdata`, which address 3 returns in bits 15:0. Writing 1 to either bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe (pops receive data) |
| host_addr | input | 3 | Register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from address |
| irq | output | 1 | Combined service interrupt |
| aud_strobe | output | 1 | Audio slot pulse |
| aud_tx_sample | output | 12 | Audio sample to codec |
| aud_rx_sample | input | 12 | Audio sample from codec |
| tel_strobe | output | 1 | Telecom slot pulse |
| tel_tx_sample | output | 14 | Telecom sample to codec |
| tel_rx_sample | input | 14 | Telecom sample from codec |
| cmd_req | output | 1 | Codec register command pending |
| cmd_word | output | 21 | Command in flight |
| cmd_ack | input | 1 | Codec accepts and finishes command |
| cmd_rdata | input | 16 | Read result returned with the acknowledge |

## Verification
The transmit sample is valid in the same cycle its strobe is high. The receive sample is taken at the clock edge that ends that strobe cycle. Register writes are visible one edge after the write cycle, and command completion flags are set one edge after the acknowledge. The bench samples all outputs at the falling edge and drives inputs just after it. It changes the receive inputs only a cycle after each strobe and places FIFO pushes away from slot edges. Its queue model therefore pairs each popped sample with the exact slot that consumed or produced it.

// File: rtl/codec_sched_pkg.sv
package codec_sched_pkg;

   localparam int unsigned HOST_AW = 3;
   localparam int unsigned HOST_DW = 32;

   typedef enum logic [HOST_AW-1:0] {
      SEL_CTRL = 3'd0,
      SEL_AUD  = 3'd1,
      SEL_TEL  = 3'd2,
      SEL_CMD  = 3'd3,
      SEL_STAT = 3'd4
   } host_sel_e;

   localparam int unsigned CTL_TEL_LO = 8;
   localparam int unsigned CTL_EN     = 16;
   localparam int unsigned CTL_LOOP   = 17;
   localparam int unsigned CTL_IE_LO  = 18;

   localparam int unsigned ST_WR_DONE = 16;
   localparam int unsigned ST_RD_DONE = 17;

   // bit 0 is the transmit request
   typedef struct packed {
      logic ovr;
      logic unr;
      logic rx_ne;
      logic tx_nf;
      logic rx_req;
      logic tx_req;
   } stream_stat_t;

endpackage

// File: rtl/sched_fifo.sv
module sched_fifo #(
   parameter int unsigned W     = 12,
   parameter int unsigned DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic [$clog2(DEPTH):0] count,
   output logic         full,
   output logic         empty
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = AW + 1;

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("sched_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];
   assign count   = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH)); // R6
   AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      empty && !push |=> empty); // R6

endmodule

// File: rtl/slot_timer.sv
module slot_timer #(
   parameter int unsigned DIV_W   = 7,
   parameter int unsigned MIN_DIV = 6,
   parameter int unsigned UNIT    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int unsigned UB    = $clog2(UNIT);
   localparam int unsigned CNT_W = DIV_W + UB;

   generate
      if ((1 << UB) != UNIT) begin : g_bad_unit
         $error("slot_timer: UNIT must be a power of two");
      end
      if (MIN_DIV < 1 || MIN_DIV >= (1 << DIV_W)) begin : g_bad_min
         $error("slot_timer: MIN_DIV out of range");
      end
   endgenerate

   logic [DIV_W-1:0] eff_div;
   logic [CNT_W-1:0] limit, cnt;

   assign eff_div = (div < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div;
   assign limit   = (CNT_W'(eff_div) << UB) - CNT_W'(1);
   assign tick    = en && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!en)          cnt <= '0;
      else if (cnt >= limit) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/codec_stream.sv
module codec_stream
   import codec_sched_pkg::*;
#(
   parameter int unsigned SW    = 12,
   parameter int unsigned DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          loop_en,
   input  logic          host_push,
   input  logic [SW-1:0] host_sample,
   input  logic          host_pop,
   input  logic          clr_unr,
   input  logic          clr_ovr,
   input  logic [SW-1:0] rx_in,
   output logic          strobe,
   output logic [SW-1:0] tx_sample,
   output logic [SW-1:0] rx_head,
   output stream_stat_t  stat
);
   localparam int unsigned CW   = $clog2(DEPTH) + 1;
   localparam int unsigned HALF = DEPTH / 2;

   logic [SW-1:0] tx_head, rx_din, tx_q;
   logic [CW-1:0] tx_cnt, rx_cnt;
   logic          tx_full, tx_empty, rx_full, rx_empty;
   logic          strobe_q, unr_q, ovr_q;

   sched_fifo #(.W(SW), .DEPTH(DEPTH)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .push(host_push), .din(host_sample),
      .pop(tick), .dout(tx_head),
      .count(tx_cnt), .full(tx_full), .empty(tx_empty)
   );

   assign rx_din = loop_en ? tx_q : rx_in;

   sched_fifo #(.W(SW), .DEPTH(DEPTH)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .push(strobe_q), .din(rx_din),
      .pop(host_pop), .dout(rx_head),
      .count(rx_cnt), .full(rx_full), .empty(rx_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         tx_q     <= '0;
         unr_q    <= 1'b0;
         ovr_q    <= 1'b0;
      end else begin
         strobe_q <= tick;
         if (tick && !tx_empty) tx_q <= tx_head;
         if (tick && tx_empty)  unr_q <= 1'b1;
         else if (clr_unr)      unr_q <= 1'b0;
         if (strobe_q && rx_full) ovr_q <= 1'b1;
         else if (clr_ovr)        ovr_q <= 1'b0;
      end
   end

   assign strobe      = strobe_q;
   assign tx_sample   = tx_q;
   assign stat.tx_req = (tx_cnt <= CW'(HALF));
   assign stat.rx_req = (rx_cnt >= CW'(HALF));
   assign stat.tx_nf  = !tx_full;
   assign stat.rx_ne  = !rx_empty;
   assign stat.unr    = unr_q;
   assign stat.ovr    = ovr_q;

   AST_SLOT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_q |=> !strobe_q); // R2
   AST_UNDERRUN_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      tick && tx_empty |=> $stable(tx_q) && unr_q); // R5
   AST_OVERRUN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_q && rx_full && !host_pop |=> rx_full && ovr_q); // R6

endmodule

// File: rtl/cmd_channel.sv
module cmd_channel #(
   parameter int unsigned CMD_W = 21,
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             push,
   input  logic [CMD_W-1:0] cmd_in,
   input  logic             ack,
   input  logic [DW-1:0]    rdata_in,
   input  logic             clr_wr,
   input  logic             clr_rd,
   output logic             req,
   output logic [CMD_W-1:0] word,
   output logic             wr_done,
   output logic             rd_done,
   output logic [DW-1:0]    rd_data
);
   localparam int unsigned RW_BIT = DW;

   generate
      if (CMD_W <= DW + 1) begin : g_bad_cmd
         $error("cmd_channel: CMD_W too small for data and direction");
      end
   endgenerate

   logic [CMD_W-1:0]          head;
   logic [$clog2(DEPTH):0]    cnt;
   logic                      full, empty, issue, finish;

   assign issue  = en && !req && !empty;
   assign finish = req && ack;

   sched_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n),
      .push(push), .din(cmd_in),
      .pop(issue), .dout(head),
      .count(cnt), .full(full), .empty(empty)
   );

   logic unused_cmdq;
   assign unused_cmdq = ^{cnt, full};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req     <= 1'b0;
         word    <= '0;
         wr_done <= 1'b0;
         rd_done <= 1'b0;
         rd_data <= '0;
      end else begin
         if (issue) begin
            req  <= 1'b1;
            word <= head;
         end else if (finish) begin
            req <= 1'b0;
         end
         if (finish && word[RW_BIT])       wr_done <= 1'b1;
         else if (clr_wr)                  wr_done <= 1'b0;
         if (finish && !word[RW_BIT]) begin
            rd_done <= 1'b1;
            rd_data <= rdata_in;
         end else if (clr_rd) begin
            rd_done <= 1'b0;
         end
      end
   end

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req && !ack |=> req && $stable(word)); // R10
   AST_WR_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
      req && ack && word[RW_BIT] |=> wr_done && !req); // R11
   AST_RD_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
      req && ack && !word[RW_BIT] |=> rd_done && (rd_data == $past(rdata_in))); // R11

endmodule

// File: rtl/codec_slot_sched.sv
module codec_slot_sched
   import codec_sched_pkg::*;
#(
   parameter int unsigned DEPTH     = 8,
   parameter int unsigned CMD_DEPTH = 4,
   parameter int unsigned DIV_W     = 7,
   parameter int unsigned UNIT      = 32,
   parameter int unsigned AUD_MIN   = 6,
   parameter int unsigned TEL_MIN   = 16,
   parameter int unsigned AUD_SW    = 12,
   parameter int unsigned TEL_SW    = 14,
   parameter int unsigned REG_DW    = 16,
   parameter int unsigned REG_AW    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_we,
   input  logic               host_re,
   input  logic [2:0]         host_addr,
   input  logic [31:0]        host_wdata,
   output logic [31:0]        host_rdata,
   output logic               irq,
   output logic               aud_strobe,
   output logic [11:0]        aud_tx_sample,
   input  logic [11:0]        aud_rx_sample,
   output logic               tel_strobe,
   output logic [13:0]        tel_tx_sample,
   input  logic [13:0]        tel_rx_sample,
   output logic               cmd_req,
   output logic [20:0]        cmd_word,
   input  logic               cmd_ack,
   input  logic [15:0]        cmd_rdata
);
   localparam int unsigned AUD_LSB = REG_DW - AUD_SW;
   localparam int unsigned TEL_LSB = REG_DW - TEL_SW;
   localparam int unsigned CMD_W   = REG_DW + 1 + REG_AW;

   generate
      if (AUD_SW > REG_DW || TEL_SW > REG_DW) begin : g_bad_sw
         $error("codec_slot_sched: sample wider than data field");
      end
      if (CMD_W > CTL_IE_LO + 4 + 10) begin : g_bad_cmdw
         $error("codec_slot_sched: command word exceeds host width");
      end
   endgenerate

   // control fields
   logic [DIV_W-1:0] aud_div_q, tel_div_q;
   logic             en_q, loop_q;
   logic [3:0]       ie_q;

   logic wr_ctrl, wr_stat, wr_aud, wr_tel, wr_cmd, rd_aud, rd_tel;
   assign wr_ctrl = host_we && (host_addr == SEL_CTRL);
   assign wr_stat = host_we && (host_addr == SEL_STAT);
   assign wr_aud  = host_we && (host_addr == SEL_AUD);
   assign wr_tel  = host_we && (host_addr == SEL_TEL);
   assign wr_cmd  = host_we && (host_addr == SEL_CMD);
   assign rd_aud  = host_re && (host_addr == SEL_AUD);
   assign rd_tel  = host_re && (host_addr == SEL_TEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aud_div_q <= DIV_W'(AUD_MIN);
         tel_div_q <= DIV_W'(TEL_MIN);
         en_q      <= 1'b0;
         loop_q    <= 1'b0;
         ie_q      <= '0;
      end else if (wr_ctrl) begin
         aud_div_q <= host_wdata[DIV_W-1:0];
         tel_div_q <= host_wdata[CTL_TEL_LO +: DIV_W];
         en_q      <= host_wdata[CTL_EN];
         loop_q    <= host_wdata[CTL_LOOP];
         ie_q      <= host_wdata[CTL_IE_LO +: 4];
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^{host_wdata[31:CTL_IE_LO+4], host_wdata[CTL_TEL_LO-1:DIV_W]};

   // slot timers
   logic aud_tick, tel_tick;

   slot_timer #(.DIV_W(DIV_W), .MIN_DIV(AUD_MIN), .UNIT(UNIT)) u_aud_timer (
      .clk(clk), .rst_n(rst_n), .en(en_q), .div(aud_div_q), .tick(aud_tick)
   );
   slot_timer #(.DIV_W(DIV_W), .MIN_DIV(TEL_MIN), .UNIT(UNIT)) u_tel_timer (
      .clk(clk), .rst_n(rst_n), .en(en_q), .div(tel_div_q), .tick(tel_tick)
   );

   // streams
   stream_stat_t      aud_st, tel_st;
   logic [AUD_SW-1:0] aud_head;
   logic [TEL_SW-1:0] tel_head;

   codec_stream #(.SW(AUD_SW), .DEPTH(DEPTH)) u_aud (
      .clk(clk), .rst_n(rst_n), .tick(aud_tick), .loop_en(loop_q),
      .host_push(wr_aud), .host_sample(host_wdata[AUD_LSB +: AUD_SW]),
      .host_pop(rd_aud), .clr_unr(wr_stat && host_wdata[4]),
      .clr_ovr(wr_stat && host_wdata[5]), .rx_in(aud_rx_sample),
      .strobe(aud_strobe), .tx_sample(aud_tx_sample),
      .rx_head(aud_head), .stat(aud_st)
   );

   codec_stream #(.SW(TEL_SW), .DEPTH(DEPTH)) u_tel (
      .clk(clk), .rst_n(rst_n), .tick(tel_tick), .loop_en(loop_q),
      .host_push(wr_tel), .host_sample(host_wdata[TEL_LSB +: TEL_SW]),
      .host_pop(rd_tel), .clr_unr(wr_stat && host_wdata[12]),
      .clr_ovr(wr_stat && host_wdata[13]), .rx_in(tel_rx_sample),
      .strobe(tel_strobe), .tx_sample(tel_tx_sample),
      .rx_head(tel_head), .stat(tel_st)
   );

   // command channel
   logic              wr_done, rd_done;
   logic [REG_DW-1:0] rd_data;

   cmd_channel #(.CMD_W(CMD_W), .DW(REG_DW), .DEPTH(CMD_DEPTH)) u_cmd (
      .clk(clk), .rst_n(rst_n), .en(en_q),
      .push(wr_cmd), .cmd_in(host_wdata[CMD_W-1:0]),
      .ack(cmd_ack), .rdata_in(cmd_rdata),
      .clr_wr(wr_stat && host_wdata[ST_WR_DONE]),
      .clr_rd(wr_stat && host_wdata[ST_RD_DONE]),
      .req(cmd_req), .word(cmd_word),
      .wr_done(wr_done), .rd_done(rd_done), .rd_data(rd_data)
   );

   // status, read mux, interrupt
   logic [31:0] status;
   logic [3:0]  req_vec;

   assign status  = {14'd0, rd_done, wr_done, 2'd0, tel_st, 2'd0, aud_st};
   assign req_vec = {tel_st.rx_req, tel_st.tx_req, aud_st.rx_req, aud_st.tx_req};
   assign irq     = en_q && |(req_vec & ie_q);

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         SEL_CTRL: begin
            host_rdata[DIV_W-1:0]             = aud_div_q;
            host_rdata[CTL_TEL_LO +: DIV_W]   = tel_div_q;
            host_rdata[CTL_EN]                = en_q;
            host_rdata[CTL_LOOP]              = loop_q;
            host_rdata[CTL_IE_LO +: 4]        = ie_q;
         end
         SEL_AUD:  if (aud_st.rx_ne) host_rdata[AUD_LSB +: AUD_SW] = aud_head;
         SEL_TEL:  if (tel_st.rx_ne) host_rdata[TEL_LSB +: TEL_SW] = tel_head;
         SEL_CMD:  host_rdata[REG_DW-1:0] = rd_data;
         SEL_STAT: host_rdata = status;
         default:  host_rdata = '0;
      endcase
   end

   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !aud_strobe || $past(aud_tick)); // R2
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !irq); // R9
   AST_NO_ISSUE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q && !cmd_req |=> !cmd_req); // R10

endmodule

// File: tb/codec_slot_sched_bench.sv
`timescale 1ns/1ps
module codec_slot_sched_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0, host_re = 1'b0;
   logic [2:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        irq, aud_strobe, tel_strobe, cmd_req;
   logic [11:0] aud_tx_sample;
   logic [11:0] aud_rx_sample = 12'h300;
   logic [13:0] tel_tx_sample;
   logic [13:0] tel_rx_sample = 14'h1000;
   logic [20:0] cmd_word;
   logic        cmd_ack = 1'b0;
   logic [15:0] cmd_rdata = '0;

   codec_slot_sched u_codec_slot_sched (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
      .aud_strobe(aud_strobe), .aud_tx_sample(aud_tx_sample), .aud_rx_sample(aud_rx_sample),
      .tel_strobe(tel_strobe), .tel_tx_sample(tel_tx_sample), .tel_rx_sample(tel_rx_sample),
      .cmd_req(cmd_req), .cmd_word(cmd_word), .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata)
   );

   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // scoreboard state
   int  aud_txq[$], aud_rxq[$], tel_txq[$], tel_rxq[$], cmdq[$];
   int  aud_last = 0, tel_last = 0;
   int  aud_prev = -1, tel_prev = -1;
   int  aud_period = 192, tel_period = 512;
   int  aud_seen = 0;
   bit  loop_m = 0;
   bit  aud_bump = 0, tel_bump = 0;

   // audio monitor
   always @(negedge clk) begin
      if (aud_bump) begin
         aud_rx_sample <= aud_rx_sample + 12'h011;
         aud_bump = 0;
      end
      if (rst_n && aud_strobe === 1'b1) begin
         int exp, v;
         aud_seen++;
         exp = (aud_txq.size() > 0) ? aud_txq.pop_front() : aud_last;
         aud_last = exp;
         check(int'(aud_tx_sample) == exp, "R4/R5 audio tx sample", int'(aud_tx_sample), exp);
         if (aud_prev >= 0)
            check(cyc - aud_prev == aud_period, "R2 audio slot period", cyc - aud_prev, aud_period);
         aud_prev = cyc;
         v = loop_m ? exp : int'(aud_rx_sample);
         if (aud_rxq.size() < 8) aud_rxq.push_back(v);
         aud_bump = 1;
      end
   end

   // telecom monitor
   always @(negedge clk) begin
      if (tel_bump) begin
         tel_rx_sample <= tel_rx_sample + 14'h021;
         tel_bump = 0;
      end
      if (rst_n && tel_strobe === 1'b1) begin
         int exp, v;
         exp = (tel_txq.size() > 0) ? tel_txq.pop_front() : tel_last;
         tel_last = exp;
         check(int'(tel_tx_sample) == exp, "R4/R5 telecom tx sample", int'(tel_tx_sample), exp);
         if (tel_prev >= 0)
            check(cyc - tel_prev == tel_period, "R3 telecom slot period", cyc - tel_prev, tel_period);
         tel_prev = cyc;
         v = loop_m ? exp : int'(tel_rx_sample);
         if (tel_rxq.size() < 8) tel_rxq.push_back(v);
         tel_bump = 1;
      end
   end

   // codec command responder
   int dly = 0;
   always @(negedge clk) begin
      if (cmd_ack) begin
         cmd_ack <= 1'b0;
      end else if (rst_n && cmd_req) begin
         dly++;
         if (dly == 3) begin
            int exp;
            exp = (cmdq.size() > 0) ? cmdq.pop_front() : -1;
            check(int'(cmd_word) == exp, "R10 command word order", int'(cmd_word), exp);
            cmd_rdata <= 16'h5A00 | 16'(cmd_word[20:17]);
            cmd_ack   <= 1'b1;
            dly = 0;
         end
      end
   end

   // driver tasks
   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic wr(input int a, input int d);
      tick();
      host_we = 1'b1; host_addr = 3'(a); host_wdata = 32'(d);
      tick();
      host_we = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      tick();
      host_addr = 3'(a); host_re = 1'b1;
      #1 d = int'(host_rdata);
      tick();
      host_re = 1'b0;
   endtask

   task automatic set_ctrl(input int ad, input int td, input bit en, input bit lp, input int ie);
      wr(0, ad | (td << 8) | (int'(en) << 16) | (int'(lp) << 17) | (ie << 18));
      aud_period = 32 * ((ad < 6) ? 6 : ad);
      tel_period = 32 * ((td < 16) ? 16 : td);
      aud_prev = -1; tel_prev = -1;
      loop_m = lp;
   endtask

   task automatic push_aud(input int s);
      wr(1, s << 4); aud_txq.push_back(s);
   endtask

   task automatic push_tel(input int s);
      wr(2, s << 2); tel_txq.push_back(s);
   endtask

   task automatic pop_aud(input string req);
      int d, exp;
      exp = (aud_rxq.size() > 0) ? aud_rxq.pop_front() : 0;
      rd(1, d);
      check(d == (exp << 4), req, d, exp << 4);
   endtask

   task automatic wait_aud(input int n);
      for (int i = 0; i < n; i++) begin
         do @(negedge clk); while (aud_strobe !== 1'b1);
      end
      #1;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      int d, s0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      tick();
      check(aud_strobe == 0 && tel_strobe == 0, "R1 no strobe after reset", aud_strobe, 0);
      check(irq == 0 && cmd_req == 0, "R1 irq and cmd idle", {irq, cmd_req}, 0);
      rd(4, d); check(d == 32'h0505, "R1 reset status", d, 32'h0505);
      rd(1, d); check(d == 0, "R6 empty rx reads zero", d, 0);

      // disabled: fill FIFOs, no slots
      set_ctrl(6, 16, 0, 0, 0);
      push_aud(12'h123); push_aud(12'h456); push_aud(12'h789);
      push_tel(14'h1ABC); push_tel(14'h2DEF);
      rd(4, d); check(d == 32'h0505, "R8 three queued keeps tx request", d, 32'h0505);
      push_aud(12'hABC); push_aud(12'hDEF);
      rd(4, d); check(d == 32'h0504, "R8 five queued drops tx request", d, 32'h0504);
      s0 = aud_seen;
      repeat (300) tick();
      check(aud_seen == s0, "R2 no strobes while disabled", aud_seen - s0, 0);

      // enabled: 5 samples then 2 under-runs
      set_ctrl(6, 16, 1, 0, 0);
      wait_aud(7);
      rd(4, d); check((d & 32'h3F) == 32'h1F, "R5/R8 audio status after under-run", d & 32'h3F, 32'h1F);
      for (int i = 0; i < 7; i++) pop_aud("R6 audio rx order");
      wr(4, 32'h10);
      rd(4, d); check((d & 32'h10) == 0, "R5 under-run flag cleared by write-1", d & 32'h10, 0);

      // over-run
      wait_aud(10);
      rd(4, d); check((d & 32'h3F) == 32'h3F, "R6 over-run flag set on full rx", d & 32'h3F, 32'h3F);
      check((d & 32'h1000) != 0, "R5 telecom under-run flag", d & 32'h1000, 32'h1000);
      for (int i = 0; i < 8; i++) pop_aud("R6 rx keeps first eight");
      rd(1, d); check(d == 0, "R6 dropped sample not stored", d, 0);
      wr(4, 32'h20);
      rd(4, d); check((d & 32'h20) == 0, "R6 over-run flag cleared by write-1", d & 32'h20, 0);

      // loopback
      wait_aud(1);
      set_ctrl(6, 16, 1, 1, 0);
      for (int i = 0; i < 8; i++) begin
         rd(4, d);
         if ((d & 32'h8) != 0) pop_aud("R6 drain");
      end
      push_aud(12'hAAA); push_aud(12'h555);
      wait_aud(2);
      pop_aud("R7 loopback first sample");
      pop_aud("R7 loopback second sample");

      // divisor clamp and change
      set_ctrl(2, 3, 1, 0, 0);
      wait_aud(4);
      set_ctrl(8, 16, 1, 0, 0);
      wait_aud(4);

      // interrupt gating
      set_ctrl(8, 16, 0, 0, 4'b0100);
      tick(); check(irq == 0, "R9 irq held low while disabled", irq, 0);
      set_ctrl(8, 16, 1, 0, 4'b0100);
      tick(); check(irq == 1, "R9 telecom tx request raises irq", irq, 1);
      set_ctrl(8, 16, 0, 0, 4'b0001);
      for (int i = 0; i < 5; i++) push_aud(12'h100 + i);
      set_ctrl(8, 16, 1, 0, 4'b0001);
      tick(); check(irq == 0, "R9 masked-in request inactive", irq, 0);
      wait_aud(1);
      tick(); check(irq == 1, "R9 irq after count drops to four", irq, 1);

      // codec register commands
      cmdq.push_back((5 << 17) | (1 << 16) | 16'hBEEF);
      wr(3, (5 << 17) | (1 << 16) | 16'hBEEF);
      cmdq.push_back(9 << 17);
      wr(3, 9 << 17);
      for (int i = 0; i < 60; i++) tick();
      rd(4, d); check((d & 32'h30000) == 32'h30000, "R11 both completion flags", d & 32'h30000, 32'h30000);
      rd(3, d); check(d == 32'h5A09, "R11 read result", d, 32'h5A09);
      check(cmdq.size() == 0, "R10 all commands issued", cmdq.size(), 0);
      wr(4, 32'h30000);
      rd(4, d); check((d & 32'h30000) == 0, "R11 completion flags cleared", d & 32'h30000, 0);

      finish_run();
   end

endmodule